// File: doc/BRIEF.md
# Command-First Serial Register Sequencer

This block is the device-side register access engine behind a four-wire serial port (serial clock, data in, data out and an active-low chip select) of a converter. Every transaction opens with an eight-bit command byte. The byte names one of six registers, says whether the next access reads or writes it, and carries a standby flag and a two-bit input channel selector. The block then moves exactly one access of the addressed register's width and goes back to waiting for the next command byte. No register can be reached any other way.

The serial pins are sampled by the system clock through synchronizers. The serial clock idles high. Input bits are taken on its rising edges and output bits are launched on its falling edges, most significant bit first. A conversion result enters through a parallel port with a one-cycle load strobe and fills a read-only data register. A data-ready flag goes low on a load. It is visible on a pin and as the top bit of the command register readback.

Command byte, most significant bit first: bit 7 is zero for an accepted byte, bits 6:4 are the register address, bit 3 is 1 for read and 0 for write, bit 2 is standby, and bits 1:0 are the channel. The addresses are 0 command (8 bits), 1 setup (8 bits, reset 0x01), 2 clock (8 bits, reset 0x05), 3 data (16 bits, read-only, reset 0x0000), 4 offset (24 bits, reset 0x800000) and 5 gain (24 bits, reset 0x400000). Addresses 6 and 7 are unused 8-bit slots.

Top module: `cmd_serial_regs`

## Requirements
- R1: After reset `dout` and `chan` are 0, `standby` is 0 and `drdy_n` is 1. The registers hold their reset values: setup 0x01, clock 0x05, data 0x0000, offset 0x800000 and gain 0x400000.
- R2: A byte whose bit 7 is 1 is ignored, and the following byte is taken as a new command. A write command to address 0 has no data phase.
- R3: A read command is followed by the addressed register's value, most significant bit first, on the next N falling edges of the serial clock. N is 8 for addresses 0, 1, 2, 6 and 7, 16 for address 3, and 24 for addresses 4 and 5.
- R4: A write command to address 1, 2, 4 or 5 takes the next N rising-edge bits, most significant bit first, and stores them in that register.
- R5: After an access completes, the next byte is decoded as a command, whether the access was a read or a write.
- R6: Reading address 0 returns `drdy_n` in bit 7 and bits 6:0 of the command byte that requested the read.
- R7: A pulse on `result_load` stores `result` in the data register and drives `drdy_n` low. A completed read of the data register drives it high again. The data register can be read again and gives the same value.
- R8: A write to the data register is shifted in at its full 16-bit width and discarded.
- R9: If chip select goes high during a command or an access, that command or access is abandoned and no register changes. The next byte after chip select falls again is taken as a command.
- R10: `chan` and `standby` follow bits 1:0 and bit 2 of the last accepted command byte.
- R11: While `rst_n` is low, serial traffic is ignored. On release every register holds its reset value.
- R12: Addresses 6 and 7 read as 0x00, and writes to them are discarded.
- R13: Outside a read data phase, `dout` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select |
| sclk | input | 1 | Serial clock, idles high |
| din | input | 1 | Serial data into the block |
| dout | output | 1 | Serial data out of the block |
| result | input | 16 | Conversion result to be stored |
| result_load | input | 1 | One-cycle strobe that stores `result` |
| drdy_n | output | 1 | Low while an unread result is held |
| chan | output | 2 | Channel field of the last accepted command |
| standby | output | 1 | Standby field of the last accepted command |

## Verification
On every cycle the assertions check the following. A raised chip select returns the sequencer to command wait with a cleared bit counter. `dout` stays low outside a read phase. Register writes happen only at the end of a write access, and rejected bytes never load the command fields. The data register does not change on a write, a result load always drops `drdy_n`, and the bit counter stays within the widest access. Only the bench scenarios can show the rest, because the bit ordering and field values must be compared against an independent register model. That covers values read back, the per-address widths, the command readback layout, the readiness handshake across a data read, the effect of an abort, and traffic driven during reset being lost.

// File: rtl/csr_pkg.sv
package csr_pkg;
    parameter int REG_W  = 8;
    parameter int DATA_W = 16;
    parameter int CAL_W  = 24;
    parameter int ADDR_W = 3;
    parameter int CNT_W  = $clog2(CAL_W + 1);

    localparam logic [ADDR_W-1:0] A_CMD   = 3'd0;
    localparam logic [ADDR_W-1:0] A_SETUP = 3'd1;
    localparam logic [ADDR_W-1:0] A_CLOCK = 3'd2;
    localparam logic [ADDR_W-1:0] A_DATA  = 3'd3;
    localparam logic [ADDR_W-1:0] A_OFFS  = 3'd4;
    localparam logic [ADDR_W-1:0] A_GAIN  = 3'd5;

    typedef enum logic [1:0] {
        ST_CMD = 2'd0,
        ST_WR  = 2'd1,
        ST_RD  = 2'd2
    } seq_state_e;

    function automatic logic [CNT_W-1:0] acc_bits(input logic [ADDR_W-1:0] a);
        case (a)
            A_DATA:         acc_bits = CNT_W'(DATA_W);
            A_OFFS, A_GAIN: acc_bits = CNT_W'(CAL_W);
            default:        acc_bits = CNT_W'(REG_W);
        endcase
    endfunction
endpackage

// File: rtl/csr_pin_sync.sv
module csr_pin_sync #(
    parameter int           WIDTH   = 3,
    parameter int           STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_i,
    output logic [WIDTH-1:0] pin_o
);
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= {STAGES{RST_VAL[b]}};
            else        chain_q <= {chain_q[STAGES-2:0], pin_i[b]};
        end
        assign pin_o[b] = chain_q[STAGES-1];
    end
endmodule

// File: rtl/csr_seq.sv
module csr_seq
    import csr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_s,
    input  logic              sclk_s,
    input  logic              din_s,
    input  logic [CAL_W-1:0]  rd_val,
    output logic [REG_W-1:0]  peek_byte,
    output logic              cmd_load,
    output logic              wr_en,
    output logic              rd_done,
    output logic [ADDR_W-1:0] acc_addr,
    output logic [CAL_W-1:0]  wr_data,
    output logic              dout
);
    typedef struct packed {
        seq_state_e        state;
        logic [CNT_W-1:0]  cnt;
        logic [CNT_W-1:0]  len;
        logic [ADDR_W-1:0] addr;
        logic [CAL_W-1:0]  sr;
        logic [CAL_W-1:0]  out;
        logic              dout;
        logic              sclk_prev;
    } seq_t;

    seq_t q, d;
    logic rise, fall;
    logic [ADDR_W-1:0] new_addr;
    logic [CNT_W-1:0]  new_len;

    assign rise      = sclk_s & ~q.sclk_prev;
    assign fall      = ~sclk_s & q.sclk_prev;
    assign peek_byte = {q.sr[REG_W-2:0], din_s};
    assign new_addr  = peek_byte[6:4];
    assign new_len   = acc_bits(new_addr);

    always_comb begin
        d           = q;
        d.sclk_prev = sclk_s;
        cmd_load    = 1'b0;
        wr_en       = 1'b0;
        rd_done     = 1'b0;
        if (cs_n_s) begin
            d.state = ST_CMD;
            d.cnt   = '0;
            d.dout  = 1'b0;
        end else if (rise) begin
            d.sr  = {q.sr[CAL_W-2:0], din_s};
            d.cnt = q.cnt + 1'b1;
            case (q.state)
                ST_CMD: begin
                    if (q.cnt == CNT_W'(REG_W - 1)) begin
                        d.cnt = '0;
                        if (!peek_byte[7]) begin
                            cmd_load = 1'b1;
                            d.addr   = new_addr;
                            d.len    = new_len;
                            if (peek_byte[3]) begin
                                d.state = ST_RD;
                                d.out   = rd_val << (CNT_W'(CAL_W) - new_len);
                            end else if (new_addr != A_CMD) begin
                                d.state = ST_WR;
                            end
                        end
                    end
                end
                ST_WR: begin
                    if (q.cnt == q.len - 1'b1) begin
                        wr_en   = 1'b1;
                        d.state = ST_CMD;
                        d.cnt   = '0;
                    end
                end
                default: begin
                    if (q.cnt == q.len - 1'b1) begin
                        rd_done = 1'b1;
                        d.state = ST_CMD;
                        d.cnt   = '0;
                        d.dout  = 1'b0;
                    end
                end
            endcase
        end else if (fall && q.state == ST_RD) begin
            d.dout = q.out[CAL_W-1];
            d.out  = {q.out[CAL_W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.state     <= ST_CMD;
            q.cnt       <= '0;
            q.len       <= CNT_W'(REG_W);
            q.addr      <= A_CMD;
            q.sr        <= '0;
            q.out       <= '0;
            q.dout      <= 1'b0;
            q.sclk_prev <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign acc_addr = q.addr;
    assign wr_data  = {q.sr[CAL_W-2:0], din_s};
    assign dout     = q.dout;

    AST_CS_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_s |=> (q.state == ST_CMD && q.cnt == '0)); // R9
    AST_DOUT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state != ST_RD) |-> !dout); // R13
    AST_WR_IN_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (q.state == ST_WR && !cs_n_s)); // R4
    AST_REJECT_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_load |-> (q.state == ST_CMD && !peek_byte[7])); // R2
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt < CNT_W'(CAL_W)); // R3
endmodule

// File: rtl/csr_regbank.sv
module csr_regbank
    import csr_pkg::*;
#(
    parameter logic [REG_W-1:0] SETUP_RST = 8'h01,
    parameter logic [REG_W-1:0] CLOCK_RST = 8'h05,
    parameter logic [CAL_W-1:0] OFFS_RST  = 24'h800000,
    parameter logic [CAL_W-1:0] GAIN_RST  = 24'h400000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_W-1:0]  peek_byte,
    input  logic              cmd_load,
    input  logic              wr_en,
    input  logic              rd_done,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [CAL_W-1:0]  wr_data,
    input  logic [DATA_W-1:0] result,
    input  logic              result_load,
    output logic [CAL_W-1:0]  rd_val,
    output logic              drdy_n,
    output logic [1:0]        chan,
    output logic              standby
);
    typedef struct packed {
        logic [1:0]        chan;
        logic              stby;
        logic [REG_W-1:0]  setup;
        logic [REG_W-1:0]  clock;
        logic [DATA_W-1:0] data;
        logic [CAL_W-1:0]  offs;
        logic [CAL_W-1:0]  gain;
        logic              drdy_n;
    } bank_t;

    bank_t q, d;

    always_comb begin
        d = q;
        if (cmd_load) begin
            d.chan = peek_byte[1:0];
            d.stby = peek_byte[2];
        end
        if (wr_en) begin
            case (acc_addr)
                A_SETUP: d.setup = wr_data[REG_W-1:0];
                A_CLOCK: d.clock = wr_data[REG_W-1:0];
                A_OFFS:  d.offs  = wr_data;
                A_GAIN:  d.gain  = wr_data;
                default: ;
            endcase
        end
        if (rd_done && acc_addr == A_DATA) d.drdy_n = 1'b1;
        if (result_load) begin
            d.data   = result;
            d.drdy_n = 1'b0;
        end
    end

    always_comb begin
        case (peek_byte[6:4])
            A_CMD:   rd_val = CAL_W'({q.drdy_n, peek_byte[6:0]});
            A_SETUP: rd_val = CAL_W'(q.setup);
            A_CLOCK: rd_val = CAL_W'(q.clock);
            A_DATA:  rd_val = CAL_W'(q.data);
            A_OFFS:  rd_val = q.offs;
            A_GAIN:  rd_val = q.gain;
            default: rd_val = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.chan   <= 2'd0;
            q.stby   <= 1'b0;
            q.setup  <= SETUP_RST;
            q.clock  <= CLOCK_RST;
            q.data   <= '0;
            q.offs   <= OFFS_RST;
            q.gain   <= GAIN_RST;
            q.drdy_n <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign drdy_n  = q.drdy_n;
    assign chan    = q.chan;
    assign standby = q.stby;

    AST_DATA_RO: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && acc_addr == A_DATA && !result_load) |=> $stable(q.data)); // R8
    AST_LOAD_READY: assert property (@(posedge clk) disable iff (!rst_n)
        result_load |=> !drdy_n); // R7
endmodule

// File: rtl/cmd_serial_regs.sv
module cmd_serial_regs
    import csr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              din,
    output logic              dout,
    input  logic [DATA_W-1:0] result,
    input  logic              result_load,
    output logic              drdy_n,
    output logic [1:0]        chan,
    output logic              standby
);
    logic [2:0]        pins_s;
    logic [REG_W-1:0]  peek_byte;
    logic              cmd_load, wr_en, rd_done;
    logic [ADDR_W-1:0] acc_addr;
    logic [CAL_W-1:0]  wr_data, rd_val;

    csr_pin_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b110)) i_sync (
        .clk(clk), .rst_n(rst_n), .pin_i({cs_n, sclk, din}), .pin_o(pins_s)
    );

    csr_seq i_seq (
        .clk(clk), .rst_n(rst_n),
        .cs_n_s(pins_s[2]), .sclk_s(pins_s[1]), .din_s(pins_s[0]),
        .rd_val(rd_val), .peek_byte(peek_byte), .cmd_load(cmd_load),
        .wr_en(wr_en), .rd_done(rd_done), .acc_addr(acc_addr),
        .wr_data(wr_data), .dout(dout)
    );

    csr_regbank i_bank (
        .clk(clk), .rst_n(rst_n), .peek_byte(peek_byte), .cmd_load(cmd_load),
        .wr_en(wr_en), .rd_done(rd_done), .acc_addr(acc_addr), .wr_data(wr_data),
        .result(result), .result_load(result_load), .rd_val(rd_val),
        .drdy_n(drdy_n), .chan(chan), .standby(standby)
    );
endmodule

// File: tb/test_cmd_serial_regs.sv
module test_cmd_serial_regs;
    localparam int CLK_PERIOD = 10;
    localparam int HALF = 8;

    logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sclk = 1'b1, din = 1'b0;
    logic result_load = 1'b0;
    logic [15:0] result = '0;
    logic dout, drdy_n, standby;
    logic [1:0] chan;

    int nchk = 0, nfail = 0;

    logic [7:0]  m_setup, m_clock;
    logic [15:0] m_data;
    logic [23:0] m_offs, m_gain;
    logic        m_drdy, m_stby;
    logic [1:0]  m_chan;

    always #(CLK_PERIOD/2) clk = ~clk;

    cmd_serial_regs i_cmd_serial_regs (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din),
        .dout(dout), .result(result), .result_load(result_load),
        .drdy_n(drdy_n), .chan(chan), .standby(standby)
    );

    function automatic int bw(input logic [2:0] a);
        if (a == 3'd3) return 16;
        if (a == 3'd4 || a == 3'd5) return 24;
        return 8;
    endfunction

    function automatic logic [23:0] expect_rd(input logic [2:0] a);
        case (a)
            3'd0: return {16'h0, m_drdy, 3'b000, 1'b1, m_stby, m_chan};
            3'd1: return {16'h0, m_setup};
            3'd2: return {16'h0, m_clock};
            3'd3: return {8'h0, m_data};
            3'd4: return m_offs;
            3'd5: return m_gain;
            default: return 24'h0;
        endcase
    endfunction

    task automatic model_reset();
        m_setup = 8'h01; m_clock = 8'h05; m_data = 16'h0;
        m_offs = 24'h800000; m_gain = 24'h400000;
        m_drdy = 1'b1; m_stby = 1'b0; m_chan = 2'd0;
    endtask

    task automatic check(input string tag, input logic [23:0] act, input logic [23:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic xfer(input logic [23:0] wv, input int n, output logic [23:0] rv);
        rv = '0;
        for (int i = n - 1; i >= 0; i--) begin
            sclk = 1'b0; din = wv[i];
            wait_clk(HALF);
            rv[i] = dout;
            sclk = 1'b1;
            wait_clk(HALF);
        end
    endtask

    task automatic send_cmd(input logic [2:0] a, input logic rd, input logic s, input logic [1:0] c);
        logic [23:0] junk;
        xfer({16'h0, 1'b0, a, rd, s, c}, 8, junk);
        m_stby = s; m_chan = c;
    endtask

    task automatic reg_read(input logic [2:0] a, input logic s, input logic [1:0] c,
                            output logic [23:0] v);
        cs_n = 1'b0; wait_clk(4);
        send_cmd(a, 1'b1, s, c);
        xfer(24'h0, bw(a), v);
        if (a == 3'd3) m_drdy = 1'b1;
        wait_clk(4); cs_n = 1'b1; wait_clk(4);
    endtask

    task automatic reg_write(input logic [2:0] a, input logic [23:0] v);
        logic [23:0] junk;
        cs_n = 1'b0; wait_clk(4);
        send_cmd(a, 1'b0, m_stby, m_chan);
        if (a != 3'd0) xfer(v, bw(a), junk);
        case (a)
            3'd1: m_setup = v[7:0];
            3'd2: m_clock = v[7:0];
            3'd4: m_offs = v;
            3'd5: m_gain = v;
            default: ;
        endcase
        wait_clk(4); cs_n = 1'b1; wait_clk(4);
    endtask

    task automatic load_result(input logic [15:0] v);
        @(negedge clk); result = v; result_load = 1'b1;
        @(negedge clk); result_load = 1'b0;
        m_data = v; m_drdy = 1'b0;
        wait_clk(2);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog actual=%h expected=%h", 1'b1, 1'b0);
        finish_run();
    end

    initial begin
        logic [23:0] v, junk;
        model_reset();
        wait_clk(5); rst_n = 1'b1; wait_clk(5);

        // R1 reset state at the pins and register values
        check("R1 dout", {23'h0, dout}, 24'h0);
        check("R1 drdy_n", {23'h0, drdy_n}, 24'h1);
        check("R1 chan/standby", {21'h0, standby, chan}, 24'h0);
        for (int a = 1; a <= 5; a++) begin
            reg_read(3'(a), 1'b0, 2'd0, v);
            check($sformatf("R1 R3 reset value addr %0d", a), v, expect_rd(3'(a)));
        end

        // R4 R5 write then read, and two accesses back to back under one select
        reg_write(3'd1, 24'h0000A5);
        reg_read(3'd1, 1'b0, 2'd0, v);
        check("R4 setup readback", v, 24'h0000A5);
        cs_n = 1'b0; wait_clk(4);
        send_cmd(3'd2, 1'b0, 1'b0, 2'd0); xfer(24'h00003C, 8, junk); m_clock = 8'h3C;
        send_cmd(3'd2, 1'b1, 1'b0, 2'd0); xfer(24'h0, 8, v);
        wait_clk(4); cs_n = 1'b1; wait_clk(4);
        check("R5 command after write", v, 24'h00003C);

        // R2 rejected byte, then a valid command is decoded
        cs_n = 1'b0; wait_clk(4);
        xfer(24'h000098, 8, junk);
        send_cmd(3'd2, 1'b1, 1'b0, 2'd0); xfer(24'h0, 8, v);
        wait_clk(4); cs_n = 1'b1; wait_clk(4);
        check("R2 rejected byte skipped", v, {16'h0, m_clock});
        // R2 write command to address 0 has no data phase
        cs_n = 1'b0; wait_clk(4);
        send_cmd(3'd0, 1'b0, 1'b1, 2'd2);
        send_cmd(3'd1, 1'b1, 1'b1, 2'd2); xfer(24'h0, 8, v);
        wait_clk(4); cs_n = 1'b1; wait_clk(4);
        check("R2 no data phase after addr0 write", v, {16'h0, m_setup});

        // R10 channel and standby follow the command
        check("R10 chan/standby", {21'h0, standby, chan}, 24'h6);

        // R6 command readback
        reg_read(3'd0, 1'b0, 2'd1, v);
        check("R6 command readback idle", v, expect_rd(3'd0));

        // R7 readiness handshake
        load_result(16'hBEEF);
        check("R7 drdy_n low after load", {23'h0, drdy_n}, 24'h0);
        reg_read(3'd0, 1'b1, 2'd3, v);
        check("R6 R7 readback bit7 zero", v, expect_rd(3'd0));
        reg_read(3'd3, 1'b0, 2'd0, v);
        check("R7 data value", v, 24'h00BEEF);
        check("R7 drdy_n high after read", {23'h0, drdy_n}, 24'h1);
        reg_read(3'd3, 1'b0, 2'd0, v);
        check("R7 data reread", v, 24'h00BEEF);

        // R8 data write discarded, then next byte is a command
        reg_write(3'd3, 24'h001234);
        reg_read(3'd3, 1'b0, 2'd0, v);
        check("R8 data unchanged", v, 24'h00BEEF);

        // R9 abort inside the data phase and inside the command byte
        cs_n = 1'b0; wait_clk(4);
        send_cmd(3'd1, 1'b0, 1'b0, 2'd0); xfer(24'h00000F, 4, junk);
        cs_n = 1'b1; wait_clk(6);
        reg_read(3'd1, 1'b0, 2'd0, v);
        check("R9 abort data phase", v, {16'h0, m_setup});
        cs_n = 1'b0; wait_clk(4);
        xfer(24'h000001, 3, junk);
        cs_n = 1'b1; wait_clk(6);
        reg_read(3'd2, 1'b0, 2'd0, v);
        check("R9 abort command byte", v, {16'h0, m_clock});

        // R12 unused addresses
        reg_write(3'd7, 24'h0000FF);
        reg_read(3'd7, 1'b0, 2'd0, v);
        check("R12 addr7 reads zero", v, 24'h0);
        reg_read(3'd6, 1'b0, 2'd0, v);
        check("R12 addr6 reads zero", v, 24'h0);

        // R13 dout quiet during a write phase
        cs_n = 1'b0; wait_clk(4);
        send_cmd(3'd4, 1'b0, 1'b0, 2'd0); xfer(24'hFFFFFF, 24, v); m_offs = 24'hFFFFFF;
        wait_clk(4); cs_n = 1'b1; wait_clk(4);
        check("R13 dout low in write phase", v, 24'h0);

        // random traffic against the model
        void'($urandom(32'h1D5EED));
        for (int it = 0; it < 110; it++) begin
            logic [2:0] a;
            int op;
            op = $urandom_range(0, 3);
            a = 3'($urandom_range(0, 7));
            if (op == 0) begin
                reg_write(a, 24'($urandom()));
            end else if (op == 1) begin
                load_result(16'($urandom()));
            end else begin
                logic       s;
                logic [1:0] c;
                logic [23:0] e;
                s = 1'($urandom());
                c = 2'($urandom());
                m_stby = s; m_chan = c;
                e = expect_rd(a);
                reg_read(a, s, c, v);
                check($sformatf("R3 random read addr %0d", a), v, e);
                check("R10 random chan/standby", {21'h0, standby, chan}, {21'h0, s, c});
                check("R7 random drdy_n", {23'h0, drdy_n}, {23'h0, m_drdy});
            end
        end

        // R11 traffic during reset is ignored
        load_result(16'h5A5A);
        reg_write(3'd5, 24'h123456);
        rst_n = 1'b0; wait_clk(2);
        cs_n = 1'b0; wait_clk(4);
        xfer(24'h000010, 8, junk); xfer(24'h000077, 8, junk);
        cs_n = 1'b1; wait_clk(4);
        rst_n = 1'b1; model_reset(); wait_clk(4);
        check("R11 drdy_n after reset", {23'h0, drdy_n}, 24'h1);
        reg_read(3'd1, 1'b0, 2'd0, v);
        check("R11 setup back to reset", v, 24'h000001);
        reg_read(3'd5, 1'b0, 2'd0, v);
        check("R11 gain back to reset", v, 24'h400000);
        reg_read(3'd3, 1'b0, 2'd0, v);
        check("R11 data back to reset", v, 24'h000000);

        finish_run();
    end
endmodule